// File: doc/BRIEF.md
# Sparse Address Decoder with AND-OR Selector

This combinational block watches a 3-bit address, formed from three separate address pins with the first pin as the most significant bit. It raises one of three select lines, and only when the address is one of three particular codes: 3, 6 or 7. The other five codes leave every select line low.

The same select lines gate three data bits into a single output. Each data bit is ANDed with its own select line, and the three products are ORed together. The result is a three-input multiplexer whose inputs sit at addresses 3, 6 and 7. At every other address the output is 0.

A surrounding design uses the block where only a few codes of a small address space carry meaning. A single code comparison then drives both a one-hot enable and a one-bit data pick.

Top module: `sparse_addr_select`

## Requirements
- R1: The address is {addr_msb, addr_mid, addr_lsb}, with addr_msb as the most significant bit. For example, addr_msb=1, addr_mid=1, addr_lsb=0 is address 6.
- R2: sel_line[0] is 1 exactly when the address is 3.
- R3: sel_line[1] is 1 exactly when the address is 6.
- R4: sel_line[2] is 1 exactly when the address is 7.
- R5: At address 3, mux_out equals din_a.
- R6: At address 6, mux_out equals din_b.
- R7: At address 7, mux_out equals din_c.
- R8: At addresses 0, 1, 2, 4 and 5, sel_line is 3'b000 and mux_out is 0, whatever the data inputs are.
- R9: At most one bit of sel_line is 1 for any input combination.
- R10: The two data inputs that are not selected have no effect on mux_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_msb | input | 1 | Address bit 2 (most significant) |
| addr_mid | input | 1 | Address bit 1 |
| addr_lsb | input | 1 | Address bit 0 (least significant) |
| din_a | input | 1 | Data bit passed at address 3 |
| din_b | input | 1 | Data bit passed at address 6 |
| din_c | input | 1 | Data bit passed at address 7 |
| sel_line | output | 3 | One-hot select lines: bit 0 for address 3, bit 1 for 6, bit 2 for 7 |
| mux_out | output | 1 | Selected data bit, or 0 at an unused address |

## Verification
The bench drives all 8 addresses against all 8 data patterns, 64 cases in total. This separates a select line placed at the wrong code from one that is merely inverted, and it exposes a gate that leaks data at an unused address. A swapped address-bit order is caught by the pair of addresses 6 and 3, which are mirror images of each other. For each selected address, a separate pass holds the chosen data bit fixed while the other two data bits run through every value. That pass shows whether the AND gating really blocks the inputs that are not chosen.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int SAD_ADDR_W    = 3;
  localparam int SAD_NUM_LINES = 3;

  typedef logic [SAD_ADDR_W-1:0]    sad_addr_t;
  typedef logic [SAD_NUM_LINES-1:0] sad_lines_t;

  // Codes packed low line first: line0=3, line1=6, line2=7.
  localparam logic [SAD_NUM_LINES*SAD_ADDR_W-1:0] SAD_CODES = {3'd7, 3'd6, 3'd3};

  // Product of address literals: each bit taken true or inverted per the code.
  function automatic logic sad_minterm(input sad_addr_t addr, input sad_addr_t code);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < SAD_ADDR_W; i++) begin
      acc = acc & (code[i] ? addr[i] : ~addr[i]);
    end
    return acc;
  endfunction

  // AND each data bit with its line, then OR the products.
  function automatic logic sad_and_or(input sad_lines_t lines, input sad_lines_t data);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < SAD_NUM_LINES; i++) begin
      acc = acc | (lines[i] & data[i]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/sad_minterm.sv
module sad_minterm #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CODE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] literal;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_lit
    if (CODE[i]) begin : g_true
      assign literal[i] = addr[i];
    end else begin : g_inv
      assign literal[i] = ~addr[i];
    end
  end

  assign hit = &literal;
endmodule

// File: rtl/sad_line_decoder.sv
module sad_line_decoder #(
  parameter int ADDR_W    = 3,
  parameter int NUM_LINES = 3,
  parameter logic [NUM_LINES*ADDR_W-1:0] CODES = '0
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_LINES-1:0] lines
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    sad_minterm #(
      .ADDR_W(ADDR_W),
      .CODE  (CODES[k*ADDR_W +: ADDR_W])
    ) u_term (
      .addr(addr),
      .hit (lines[k])
    );
  end
endmodule

// File: rtl/sad_and_or_select.sv
module sad_and_or_select #(
  parameter int NUM_LINES = 3
) (
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] data,
  output logic [NUM_LINES-1:0] products,
  output logic                 y
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_gate
    assign products[k] = lines[k] & data[k];
  end

  assign y = |products;
endmodule

// File: rtl/sparse_addr_select.sv
module sparse_addr_select
  import sad_pkg::*;
(
  input  logic       addr_msb,
  input  logic       addr_mid,
  input  logic       addr_lsb,
  input  logic       din_a,
  input  logic       din_b,
  input  logic       din_c,
  output logic [2:0] sel_line,
  output logic       mux_out
);
  localparam int ADDR_W    = SAD_ADDR_W;
  localparam int NUM_LINES = SAD_NUM_LINES;

  // Named internal wires, visible to the bound checker.
  sad_addr_t  addr_vec;
  sad_lines_t data_vec;
  sad_lines_t dec_lines;
  sad_lines_t gated;

  assign addr_vec = {addr_msb, addr_mid, addr_lsb};
  assign data_vec = {din_c, din_b, din_a};

  sad_line_decoder #(
    .ADDR_W   (ADDR_W),
    .NUM_LINES(NUM_LINES),
    .CODES    (SAD_CODES)
  ) u_dec (
    .addr (addr_vec),
    .lines(dec_lines)
  );

  sad_and_or_select #(
    .NUM_LINES(NUM_LINES)
  ) u_sel (
    .lines   (dec_lines),
    .data    (data_vec),
    .products(gated),
    .y       (mux_out)
  );

  assign sel_line = dec_lines;
endmodule

// File: rtl/sparse_addr_select_chk.sv
module sparse_addr_select_chk (
  input logic       addr_msb,
  input logic       addr_mid,
  input logic       addr_lsb,
  input logic       din_a,
  input logic       din_b,
  input logic       din_c,
  input logic [2:0] sel_line,
  input logic [2:0] gated,
  input logic       mux_out
);
  logic [2:0] a3;
  assign a3 = {addr_msb, addr_mid, addr_lsb};

  always_comb begin
    assert_line0_R2: assert (sel_line[0] == (a3 == 3'd3));
    assert_line1_R3: assert (sel_line[1] == (a3 == 3'd6));
    assert_line2_R4: assert (sel_line[2] == (a3 == 3'd7));
    assert_onehot_R9: assert ($onehot0(sel_line));
    assert_pick_a_R5: assert (!(a3 == 3'd3) || (mux_out == din_a));
    assert_pick_b_R6: assert (!(a3 == 3'd6) || (mux_out == din_b));
    assert_pick_c_R7: assert (!(a3 == 3'd7) || (mux_out == din_c));
    assert_idle_R8: assert ((sel_line != 3'b000) || (!mux_out && gated == 3'b000));
    assert_gate_R10: assert ((gated & ~sel_line) == 3'b000);
  end
endmodule

bind sparse_addr_select sparse_addr_select_chk u_chk (
  .addr_msb(addr_msb),
  .addr_mid(addr_mid),
  .addr_lsb(addr_lsb),
  .din_a   (din_a),
  .din_b   (din_b),
  .din_c   (din_c),
  .sel_line(sel_line),
  .gated   (gated),
  .mux_out (mux_out)
);

// File: tb/sparse_addr_select_bench.sv
module sparse_addr_select_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       addr_msb, addr_mid, addr_lsb, din_a, din_b, din_c;
  logic [2:0] sel_line;
  logic       mux_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  sparse_addr_select u_sparse_addr_select (
    .addr_msb(addr_msb), .addr_mid(addr_mid), .addr_lsb(addr_lsb),
    .din_a(din_a), .din_b(din_b), .din_c(din_c),
    .sel_line(sel_line), .mux_out(mux_out)
  );

  // Expected lines computed arithmetically: bit k set when addr equals its code.
  function automatic logic [2:0] exp_lines(input int addr);
    logic [2:0] r;
    r = 3'b000;
    if (addr == 3) r = 3'b001;
    if (addr == 6) r = 3'b010;
    if (addr == 7) r = 3'b100;
    return r;
  endfunction

  function automatic logic exp_mux(input int addr, input int data);
    // data bit0 = a, bit1 = b, bit2 = c
    if (addr == 3) return logic'((data >> 0) & 1);
    if (addr == 6) return logic'((data >> 1) & 1);
    if (addr == 7) return logic'((data >> 2) & 1);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input int addr, input int data);
    @(negedge clk);
    {addr_msb, addr_mid, addr_lsb} = 3'(addr);
    {din_c, din_b, din_a} = 3'(data);
    @(posedge clk);
    #1;
  endtask

  function automatic string line_tag(input int addr);
    if (addr == 3) return "R2";
    if (addr == 6) return "R3";
    if (addr == 7) return "R4";
    return "R8";
  endfunction

  function automatic string mux_tag(input int addr);
    if (addr == 3) return "R5";
    if (addr == 6) return "R6";
    if (addr == 7) return "R7";
    return "R8";
  endfunction

  initial begin
    {addr_msb, addr_mid, addr_lsb, din_a, din_b, din_c} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Quiet state: all-zero inputs give idle outputs (R8)
    check("R8 quiet sel_line", sel_line, 3'b000);
    check("R8 quiet mux_out", {2'b00, mux_out}, 3'b000);

    // R1: bit order; 3'b110 must be address 6, its mirror 3'b011 address 3
    apply(6, 3'b010);
    check("R1 msb-first addr6 sel_line", sel_line, 3'b010);
    apply(3, 3'b001);
    check("R1 msb-first addr3 sel_line", sel_line, 3'b001);

    // Exhaustive sweep
    for (int ad = 0; ad < 8; ad++) begin
      for (int dt = 0; dt < 8; dt++) begin
        apply(ad, dt);
        check(line_tag(ad), sel_line, exp_lines(ad));
        check(mux_tag(ad), {2'b00, mux_out}, {2'b00, exp_mux(ad, dt)});
        check("R9 onehot0", {2'b00, logic'($countones(sel_line) <= 1)}, 3'b001);
      end
    end

    // R10: hold the chosen bit, vary the other two
    for (int k = 0; k < 3; k++) begin
      int ad;
      ad = (k == 0) ? 3 : (k == 1) ? 6 : 7;
      for (int keep = 0; keep < 2; keep++) begin
        for (int oth = 0; oth < 4; oth++) begin
          int dt;
          int lo;
          lo = oth & ((1 << k) - 1);
          dt = (keep << k) | lo | ((oth >> k) << (k + 1));
          apply(ad, dt);
          check("R10 unselected data ignored", {2'b00, mux_out}, {2'b00, logic'(keep)});
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule